// File: doc/BRIEF.md
# Paged Hardware Stack Pointer Unit

This block keeps the stack pointer of an 8-bit processor whose stack lives in one fixed page of 64 bytes. The register holds only a 6-bit offset. The 13-bit memory address it presents is always that offset with the constant tag `0000011` above it, so every stack address lies in 0x00C0..0x00FF. The pointer always names the next free byte. It starts at 0x00FF after system reset or after a stack-reset command. When it runs past the bottom of the page it wraps to the top without any error, and older bytes are then overwritten.

The block serves single-byte push and pop requests, and it drives a simple RAM port. That port has a write strobe, a read strobe and a read path that returns data in the same cycle. A small sequencer also stores and restores whole frames. A subroutine-call frame holds two bytes: the return address low byte, then the upper five address bits zero-extended. An interrupt frame holds five bytes: program counter low, program counter high, index, accumulator, and the condition codes with ones in the three unused upper bits. The return and return-from-interrupt sequences pop the same bytes in reverse order. They present the rebuilt values while `frame_done` is high.

The sequencer has three states. In `ST_IDLE` the block takes requests in a fixed priority order. A call or interrupt request moves it to `ST_PUSH_FRAME`, and a return or return-from-interrupt request moves it to `ST_POP_FRAME`. Either frame state goes back to `ST_IDLE` after its last byte, and `frame_done` then pulses for one cycle. A stack reset in a frame state also sends it back to `ST_IDLE`. That path aborts the frame with no further access and no `frame_done`.

Top module: `stack_page_ptr`

## Requirements
- R1: After reset, `sp_addr` is 0x00FF, and `busy`, `pop_valid` and `frame_done` are low.
- R2: Bits 12..6 of `sp_addr` and of `mem_addr` are always `0000011`.
- R3: A single push writes `push_data` at the current `sp_addr`. The offset then drops by one modulo 64, visible in the next cycle.
- R4: A single pop reads at offset+1 modulo 64 and moves `sp_addr` to that address. The byte read appears on `pop_data` in the next cycle, with `pop_valid` high for one cycle.
- R5: A push at 0x00C0 leaves the pointer at 0x00FF, and the next push overwrites 0x00FF. A pop at 0x00FF reads 0x00C0.
- R6: `sp_reset` puts the pointer at 0x00FF in the next cycle, in any state. It blocks any RAM access in that cycle and aborts a frame in progress without asserting `frame_done`.
- R7: A call request writes `pc_in[7:0]` and then `{3'b000, pc_in[12:8]}` on two consecutive cycles at falling addresses. It leaves the pointer two lower.
- R8: An interrupt request writes five bytes on consecutive cycles in this order: `pc_in[7:0]`, `{3'b000, pc_in[12:8]}`, `idx_in`, `acc_in`, `{3'b111, ccr_in}`.
- R9: A return request pops two bytes. When `frame_done` is high, `rest_pc` equals the address saved by the matching call.
- R10: A return-from-interrupt request pops five bytes. When `frame_done` is high, `rest_ccr`, `rest_acc`, `rest_idx` and `rest_pc` equal the values saved by the matching interrupt frame, and `frame_irq` is 1.
- R11: `busy` is high from the cycle after a frame request is accepted until its last byte is done. While `busy` is high, frame, push and pop requests have no effect, and a write and a read never happen together.
- R12: In `ST_IDLE`, when several requests arrive in the same cycle, the order is `sp_reset`, then call, interrupt, return, return-from-interrupt, push, and pop last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low system reset |
| sp_reset | input | 1 | Stack reset command |
| push_req | input | 1 | Single-byte push |
| push_data | input | 8 | Byte to push |
| pop_req | input | 1 | Single-byte pop |
| call_req | input | 1 | Push call frame |
| irq_req | input | 1 | Push interrupt frame |
| ret_req | input | 1 | Pop call frame |
| rti_req | input | 1 | Pop interrupt frame |
| pc_in | input | 13 | Program counter to save |
| acc_in | input | 8 | Accumulator to save |
| idx_in | input | 8 | Index register to save |
| ccr_in | input | 5 | Condition codes to save |
| mem_rdata | input | 8 | RAM read data, same cycle |
| sp_addr | output | 13 | Address of next free byte |
| mem_addr | output | 13 | RAM address |
| mem_we | output | 1 | RAM write strobe |
| mem_wdata | output | 8 | RAM write data |
| mem_re | output | 1 | RAM read strobe |
| pop_data | output | 8 | Byte from single pop |
| pop_valid | output | 1 | `pop_data` valid pulse |
| busy | output | 1 | Frame in progress |
| frame_done | output | 1 | Frame finished pulse |
| frame_irq | output | 1 | Finished frame was interrupt type |
| rest_pc | output | 13 | Restored program counter |
| rest_acc | output | 8 | Restored accumulator |
| rest_idx | output | 8 | Restored index register |
| rest_ccr | output | 5 | Restored condition codes |

## Verification
The assertions check the per-cycle pointer rules on every cycle. These are the fixed page tag, a write at the current address followed by a decrement, and a read at offset+1 followed by a move to that address. They also cover the forced return to 0x00FF after a stack reset, the rule that a write and a read never share a cycle, and the link between `frame_done` and the fall of `busy`. Some behaviour needs a scenario and a RAM model instead. That covers byte order inside frames, the bytes read back after a 64-byte wrap, requests ignored while busy, priority between simultaneous requests, and a frame aborted after its first byte.

// File: rtl/stkp_pkg.sv
`timescale 1ns/1ps
package stkp_pkg;
    localparam int DATA_W    = 8;
    localparam int ADDR_W    = 13;
    localparam int PTR_W     = 6;
    localparam int CC_W      = 5;
    localparam int CALL_LEN  = 2;
    localparam int IRQ_LEN   = 5;
    localparam int FRAME_MAX = IRQ_LEN;
    localparam int STEP_W    = $clog2(FRAME_MAX);
    localparam int TAG_W     = ADDR_W - PTR_W;
    localparam logic [TAG_W-1:0] PAGE_TAG = 7'b0000011;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PUSH_FRAME,
        ST_POP_FRAME
    } seq_state_e;

    typedef enum logic {
        FK_CALL,
        FK_IRQ
    } frame_kind_e;
endpackage

// File: rtl/stkp_pointer.sv
`timescale 1ns/1ps
module stkp_pointer #(
    parameter int PTR_W = stkp_pkg::PTR_W,
    parameter int ADDR_W = stkp_pkg::ADDR_W,
    parameter logic [ADDR_W-PTR_W-1:0] TAG = stkp_pkg::PAGE_TAG
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_top,
    input  logic              dec,
    input  logic              inc,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [ADDR_W-1:0] pop_addr
);
    logic [PTR_W-1:0] ptr_q;
    logic [PTR_W-1:0] ptr_up;

    assign ptr_up = ptr_q + PTR_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        ptr_q <= '1;
        else if (load_top) ptr_q <= '1;
        else if (dec)      ptr_q <= ptr_q - PTR_W'(1);
        else if (inc)      ptr_q <= ptr_up;
    end

    assign cur_addr = {TAG, ptr_q};
    assign pop_addr = {TAG, ptr_up};
endmodule

// File: rtl/stkp_frame.sv
`timescale 1ns/1ps
module stkp_frame
    import stkp_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W,
    parameter int CW = CC_W,
    parameter int NB = FRAME_MAX
) (
    input  logic [AW-1:0]         pc_in,
    input  logic [DW-1:0]         acc_in,
    input  logic [DW-1:0]         idx_in,
    input  logic [CW-1:0]         ccr_in,
    input  logic [NB-1:0][DW-1:0] pop_bytes,
    input  frame_kind_e           kind,
    output logic [NB-1:0][DW-1:0] call_bytes,
    output logic [NB-1:0][DW-1:0] irq_bytes,
    output logic [AW-1:0]         rest_pc,
    output logic [DW-1:0]         rest_acc,
    output logic [DW-1:0]         rest_idx,
    output logic [CW-1:0]         rest_ccr
);
    localparam int HI_W  = AW - DW;
    localparam int HI_PAD = DW - HI_W;
    localparam int CC_PAD = DW - CW;

    logic [DW-1:0] pc_lo_b;
    logic [DW-1:0] pc_hi_b;

    assign pc_lo_b = pc_in[DW-1:0];
    assign pc_hi_b = {{HI_PAD{1'b0}}, pc_in[AW-1:DW]};

    always_comb begin
        call_bytes    = '0;
        call_bytes[0] = pc_lo_b;
        call_bytes[1] = pc_hi_b;
        irq_bytes     = '0;
        irq_bytes[0]  = pc_lo_b;
        irq_bytes[1]  = pc_hi_b;
        irq_bytes[2]  = idx_in;
        irq_bytes[3]  = acc_in;
        irq_bytes[4]  = {{CC_PAD{1'b1}}, ccr_in};
    end

    // Popped bytes arrive in reverse push order.
    always_comb begin
        rest_acc = '0;
        rest_idx = '0;
        rest_ccr = '0;
        if (kind == FK_IRQ) begin
            rest_ccr = pop_bytes[0][CW-1:0];
            rest_acc = pop_bytes[1];
            rest_idx = pop_bytes[2];
            rest_pc  = {pop_bytes[3][HI_W-1:0], pop_bytes[4]};
        end else begin
            rest_pc  = {pop_bytes[0][HI_W-1:0], pop_bytes[1]};
        end
    end
endmodule

// File: rtl/stkp_seq.sv
`timescale 1ns/1ps
module stkp_seq
    import stkp_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int NB = FRAME_MAX,
    parameter int SW = STEP_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sp_reset,
    input  logic                  call_req,
    input  logic                  irq_req,
    input  logic                  ret_req,
    input  logic                  rti_req,
    input  logic                  push_req,
    input  logic                  pop_req,
    input  logic [DW-1:0]         push_data,
    input  logic [NB-1:0][DW-1:0] call_bytes,
    input  logic [NB-1:0][DW-1:0] irq_bytes,
    input  logic [DW-1:0]         mem_rdata,
    output logic                  ptr_load_top,
    output logic                  ptr_dec,
    output logic                  ptr_inc,
    output logic                  use_pop_addr,
    output logic                  mem_we,
    output logic                  mem_re,
    output logic [DW-1:0]         mem_wdata,
    output logic                  busy,
    output logic                  frame_done,
    output frame_kind_e           done_kind,
    output logic [NB-1:0][DW-1:0] pop_bytes,
    output logic [DW-1:0]         pop_data,
    output logic                  pop_valid
);
    seq_state_e  state_q, state_d;
    logic [SW-1:0] step_q, step_d;
    frame_kind_e kind_q, kind_d;
    logic [NB-1:0][DW-1:0] buf_q;
    logic [SW-1:0] last_step;
    logic load_buf, cap_pop, single_pop, finish;
    logic done_q, pop_valid_q;
    logic [DW-1:0] pop_data_q;

    assign last_step = (kind_q == FK_IRQ) ? SW'(IRQ_LEN - 1) : SW'(CALL_LEN - 1);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            step_q  <= '0;
            kind_q  <= FK_CALL;
        end else begin
            state_q <= state_d;
            step_q  <= step_d;
            kind_q  <= kind_d;
        end
    end

    // Next state and outputs
    always_comb begin
        state_d      = state_q;
        step_d       = step_q;
        kind_d       = kind_q;
        ptr_load_top = 1'b0;
        ptr_dec      = 1'b0;
        ptr_inc      = 1'b0;
        use_pop_addr = 1'b0;
        mem_we       = 1'b0;
        mem_re       = 1'b0;
        mem_wdata    = '0;
        load_buf     = 1'b0;
        cap_pop      = 1'b0;
        single_pop   = 1'b0;
        finish       = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (sp_reset) begin
                    ptr_load_top = 1'b1;
                end else if (call_req) begin
                    kind_d = FK_CALL; load_buf = 1'b1; step_d = '0; state_d = ST_PUSH_FRAME;
                end else if (irq_req) begin
                    kind_d = FK_IRQ;  load_buf = 1'b1; step_d = '0; state_d = ST_PUSH_FRAME;
                end else if (ret_req) begin
                    kind_d = FK_CALL; step_d = '0; state_d = ST_POP_FRAME;
                end else if (rti_req) begin
                    kind_d = FK_IRQ;  step_d = '0; state_d = ST_POP_FRAME;
                end else if (push_req) begin
                    mem_we = 1'b1; mem_wdata = push_data; ptr_dec = 1'b1;
                end else if (pop_req) begin
                    mem_re = 1'b1; use_pop_addr = 1'b1; ptr_inc = 1'b1; single_pop = 1'b1;
                end
            end
            ST_PUSH_FRAME: begin
                if (sp_reset) begin
                    ptr_load_top = 1'b1; state_d = ST_IDLE;
                end else begin
                    mem_we = 1'b1; mem_wdata = buf_q[step_q]; ptr_dec = 1'b1;
                    if (step_q == last_step) begin
                        state_d = ST_IDLE; finish = 1'b1;
                    end else begin
                        step_d = step_q + SW'(1);
                    end
                end
            end
            ST_POP_FRAME: begin
                if (sp_reset) begin
                    ptr_load_top = 1'b1; state_d = ST_IDLE;
                end else begin
                    mem_re = 1'b1; use_pop_addr = 1'b1; ptr_inc = 1'b1; cap_pop = 1'b1;
                    if (step_q == last_step) begin
                        state_d = ST_IDLE; finish = 1'b1;
                    end else begin
                        step_d = step_q + SW'(1);
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Frame byte buffer and single-pop result
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_q       <= '0;
            done_q      <= 1'b0;
            pop_valid_q <= 1'b0;
            pop_data_q  <= '0;
        end else begin
            if (load_buf)     buf_q <= (kind_d == FK_IRQ) ? irq_bytes : call_bytes;
            else if (cap_pop) buf_q[step_q] <= mem_rdata;
            if (single_pop)   pop_data_q <= mem_rdata;
            done_q      <= finish;
            pop_valid_q <= single_pop;
        end
    end

    assign busy       = (state_q != ST_IDLE);
    assign frame_done = done_q;
    assign done_kind  = kind_q;
    assign pop_bytes  = buf_q;
    assign pop_data   = pop_data_q;
    assign pop_valid  = pop_valid_q;
endmodule

// File: rtl/stack_page_ptr.sv
`timescale 1ns/1ps
module stack_page_ptr
    import stkp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sp_reset,
    input  logic              push_req,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop_req,
    input  logic              call_req,
    input  logic              irq_req,
    input  logic              ret_req,
    input  logic              rti_req,
    input  logic [ADDR_W-1:0] pc_in,
    input  logic [DATA_W-1:0] acc_in,
    input  logic [DATA_W-1:0] idx_in,
    input  logic [CC_W-1:0]   ccr_in,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] sp_addr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_re,
    output logic [DATA_W-1:0] pop_data,
    output logic              pop_valid,
    output logic              busy,
    output logic              frame_done,
    output logic              frame_irq,
    output logic [ADDR_W-1:0] rest_pc,
    output logic [DATA_W-1:0] rest_acc,
    output logic [DATA_W-1:0] rest_idx,
    output logic [CC_W-1:0]   rest_ccr
);
    logic load_top, dec, inc, use_pop;
    logic [ADDR_W-1:0] cur_addr, pop_addr;
    logic [FRAME_MAX-1:0][DATA_W-1:0] call_bytes, irq_bytes, pop_bytes;
    frame_kind_e done_kind;

    stkp_pointer u_ptr (
        .clk(clk), .rst_n(rst_n), .load_top(load_top), .dec(dec), .inc(inc),
        .cur_addr(cur_addr), .pop_addr(pop_addr)
    );

    stkp_frame u_frame (
        .pc_in(pc_in), .acc_in(acc_in), .idx_in(idx_in), .ccr_in(ccr_in),
        .pop_bytes(pop_bytes), .kind(done_kind),
        .call_bytes(call_bytes), .irq_bytes(irq_bytes),
        .rest_pc(rest_pc), .rest_acc(rest_acc), .rest_idx(rest_idx), .rest_ccr(rest_ccr)
    );

    stkp_seq u_seq (
        .clk(clk), .rst_n(rst_n), .sp_reset(sp_reset),
        .call_req(call_req), .irq_req(irq_req), .ret_req(ret_req), .rti_req(rti_req),
        .push_req(push_req), .pop_req(pop_req), .push_data(push_data),
        .call_bytes(call_bytes), .irq_bytes(irq_bytes), .mem_rdata(mem_rdata),
        .ptr_load_top(load_top), .ptr_dec(dec), .ptr_inc(inc), .use_pop_addr(use_pop),
        .mem_we(mem_we), .mem_re(mem_re), .mem_wdata(mem_wdata),
        .busy(busy), .frame_done(frame_done), .done_kind(done_kind),
        .pop_bytes(pop_bytes), .pop_data(pop_data), .pop_valid(pop_valid)
    );

    assign sp_addr   = cur_addr;
    assign mem_addr  = use_pop ? pop_addr : cur_addr;
    assign frame_irq = (done_kind == FK_IRQ);
endmodule

// File: rtl/stack_page_ptr_chk.sv
`timescale 1ns/1ps
module stack_page_ptr_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        sp_reset,
    input logic [12:0] sp_addr,
    input logic [12:0] mem_addr,
    input logic        mem_we,
    input logic        mem_re,
    input logic        busy,
    input logic        frame_done,
    input logic        pop_valid
);
    assert_page_fixed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sp_addr[12:6] == 7'b0000011 && mem_addr[12:6] == 7'b0000011);

    assert_push_at_sp_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_addr == sp_addr);

    assert_push_dec_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> sp_addr[5:0] == ($past(sp_addr[5:0]) - 6'd1));

    assert_pop_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |-> mem_addr[5:0] == (sp_addr[5:0] + 6'd1));

    assert_pop_move_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> sp_addr == $past(mem_addr));

    assert_pop_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_re && !busy) |=> pop_valid);

    assert_stack_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sp_reset |=> sp_addr == 13'h00FF);

    assert_reset_no_access_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sp_reset |-> !mem_we && !mem_re);

    assert_no_overlap_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

    assert_done_after_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> !busy && $past(busy));
endmodule

bind stack_page_ptr stack_page_ptr_chk u_chk (.*);

// File: tb/stack_page_ptr_test.sv
`timescale 1ns/1ps
module stack_page_ptr_test;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n, sp_reset, push_req, pop_req, call_req, irq_req, ret_req, rti_req;
    logic [7:0] push_data, acc_in, idx_in, mem_rdata, mem_wdata, pop_data, rest_acc, rest_idx;
    logic [12:0] pc_in, sp_addr, mem_addr, rest_pc;
    logic [4:0] ccr_in, rest_ccr;
    logic mem_we, mem_re, pop_valid, busy, frame_done, frame_irq;

    stack_page_ptr uut (.*);

    logic [7:0] ram [0:255];
    assign mem_rdata = ram[mem_addr[7:0]];
    always @(posedge clk) if (mem_we) ram[mem_addr[7:0]] <= mem_wdata;

    int checks = 0;
    int fails = 0;
    logic [20:0] wq[$];
    logic [7:0]  rq[$];
    logic [5:0]  sp_m;
    logic [7:0]  em [0:63];

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [12:0] a_of(input logic [5:0] p);
        return {7'b0000011, p};
    endfunction

    // Monitor: compare RAM writes and single-pop results with the scoreboard
    always @(negedge clk) if (rst_n) begin
        if (mem_we) begin
            if (wq.size() == 0) chk(0, "R11 unexpected write", {11'd0, mem_addr, mem_wdata}, 0);
            else begin
                logic [20:0] e;
                e = wq.pop_front();
                chk({mem_addr, mem_wdata} == e, "R3/R7/R8 write addr+data", {mem_addr, mem_wdata}, e);
            end
        end
        if (pop_valid) begin
            if (rq.size() == 0) chk(0, "R4 unexpected pop_valid", pop_data, 0);
            else begin
                logic [7:0] e;
                e = rq.pop_front();
                chk(pop_data == e, "R4 pop_data", pop_data, e);
            end
        end
    end

    task automatic tick;
        @(posedge clk); #1;
    endtask

    task automatic push1(input logic [7:0] d);
        push_req = 1; push_data = d;
        wq.push_back({a_of(sp_m), d}); em[sp_m] = d; sp_m = sp_m - 6'd1;
        tick; push_req = 0;
    endtask

    task automatic pop1;
        sp_m = sp_m + 6'd1; rq.push_back(em[sp_m]);
        pop_req = 1; tick; pop_req = 0;
    endtask

    task automatic frame_push(input bit irq, input logic [12:0] pc, input logic [7:0] a,
                              input logic [7:0] x, input logic [4:0] cc, input bit noise);
        logic [7:0] b [5];
        int n;
        b[0] = pc[7:0]; b[1] = {3'b000, pc[12:8]}; b[2] = x; b[3] = a; b[4] = {3'b111, cc};
        n = irq ? 5 : 2;
        for (int i = 0; i < n; i++) begin
            wq.push_back({a_of(sp_m), b[i]}); em[sp_m] = b[i]; sp_m = sp_m - 6'd1;
        end
        pc_in = pc; acc_in = a; idx_in = x; ccr_in = cc;
        call_req = !irq; irq_req = irq; push_req = 1; push_data = 8'h99;   // R12: frame beats push
        tick; call_req = 0; irq_req = 0; push_req = 0;
        chk(busy == 1, "R11 busy after accept", busy, 1);
        if (noise) begin call_req = 1; irq_req = 1; push_req = 1; pop_req = 1; ret_req = 1; end
        tick; call_req = 0; irq_req = 0; push_req = 0; pop_req = 0; ret_req = 0;
        repeat (n - 1) tick;
        chk(frame_done == 1, irq ? "R8 frame_done" : "R7 frame_done", frame_done, 1);
        chk(busy == 0, "R11 busy low at end", busy, 0);
        chk(sp_addr == a_of(sp_m), irq ? "R8 sp after frame" : "R7 sp after frame", sp_addr, a_of(sp_m));
    endtask

    task automatic frame_pop(input bit irq, input logic [12:0] pc, input logic [7:0] a,
                             input logic [7:0] x, input logic [4:0] cc);
        int n;
        n = irq ? 5 : 2;
        sp_m = sp_m + 6'(n);
        ret_req = !irq; rti_req = irq;
        tick; ret_req = 0; rti_req = 0;
        repeat (n) tick;
        chk(frame_done == 1, irq ? "R10 frame_done" : "R9 frame_done", frame_done, 1);
        chk(frame_irq == irq, irq ? "R10 frame_irq" : "R9 frame_irq", frame_irq, irq);
        chk(rest_pc == pc, irq ? "R10 rest_pc" : "R9 rest_pc", rest_pc, pc);
        if (irq) begin
            chk(rest_acc == a, "R10 rest_acc", rest_acc, a);
            chk(rest_idx == x, "R10 rest_idx", rest_idx, x);
            chk(rest_ccr == cc, "R10 rest_ccr", rest_ccr, cc);
        end
        chk(sp_addr == a_of(sp_m), irq ? "R10 sp after pop" : "R9 sp after pop", sp_addr, a_of(sp_m));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 0; sp_reset = 0; push_req = 0; pop_req = 0; call_req = 0; irq_req = 0;
        ret_req = 0; rti_req = 0; push_data = 0; pc_in = 0; acc_in = 0; idx_in = 0; ccr_in = 0;
        sp_m = 6'h3F;
        repeat (3) @(posedge clk); #1 rst_n = 1;

        // R1
        chk(sp_addr == 13'h00FF, "R1 sp after reset", sp_addr, 13'h00FF);
        chk(busy == 0 && pop_valid == 0 && frame_done == 0, "R1 flags after reset",
            {busy, pop_valid, frame_done}, 0);

        // R3 / R4 single bytes
        push1(8'hA1); push1(8'hB2); push1(8'hC3);
        chk(sp_addr == 13'h00FC, "R3 sp after 3 pushes", sp_addr, 13'h00FC);
        pop1; pop1; pop1; tick;
        chk(sp_addr == 13'h00FF, "R4 sp after 3 pops", sp_addr, 13'h00FF);

        // R5 wrap over 64 pushes
        for (int i = 0; i < 64; i++) push1(8'h40 + 8'(i));
        chk(sp_addr == 13'h00FF, "R5 sp wraps to top", sp_addr, 13'h00FF);
        push1(8'hEE);
        chk(sp_addr == 13'h00FE, "R5 sp after overwrite", sp_addr, 13'h00FE);
        pop1; pop1; tick;
        chk(sp_addr == 13'h00C0, "R5 pop wraps to bottom", sp_addr, 13'h00C0);

        // R6 stack reset
        sp_reset = 1; tick; sp_reset = 0; sp_m = 6'h3F;
        chk(sp_addr == 13'h00FF, "R6 sp after stack reset", sp_addr, 13'h00FF);

        // R12 priorities
        push_req = 1; pop_req = 1; push_data = 8'h5D;
        wq.push_back({a_of(sp_m), 8'h5D}); em[sp_m] = 8'h5D; sp_m = sp_m - 6'd1;
        tick; push_req = 0; pop_req = 0;
        chk(sp_addr == 13'h00FE, "R12 push beats pop", sp_addr, 13'h00FE);
        sp_reset = 1; push_req = 1; call_req = 1; push_data = 8'h77;
        tick; sp_reset = 0; push_req = 0; call_req = 0; sp_m = 6'h3F;
        chk(sp_addr == 13'h00FF && busy == 0, "R12 reset beats push and call", {busy, sp_addr}, 13'h00FF);

        // R7 / R9 call and return
        push1(8'h11);
        frame_push(0, 13'h1A5C, 8'h00, 8'h00, 5'h00, 0);
        frame_pop(0, 13'h1A5C, 8'h00, 8'h00, 5'h00);

        // R8 / R10 interrupt frame and return
        frame_push(1, 13'h0F37, 8'h5A, 8'hC3, 5'h15, 0);
        frame_pop(1, 13'h0F37, 8'h5A, 8'hC3, 5'h15);

        // R11 requests ignored while busy
        frame_push(1, 13'h1234, 8'h81, 8'h7E, 5'h0A, 1);
        frame_pop(1, 13'h1234, 8'h81, 8'h7E, 5'h0A);
        pop1; tick;
        chk(sp_addr == 13'h00FF, "R11 stack balanced", sp_addr, 13'h00FF);

        // R6 abort a call frame after its first byte
        pc_in = 13'h0ABC; call_req = 1;
        wq.push_back({a_of(sp_m), 8'hBC}); em[sp_m] = 8'hBC;
        tick; call_req = 0;
        tick; sp_reset = 1;
        tick; sp_reset = 0; sp_m = 6'h3F;
        chk(busy == 0, "R6 abort clears busy", busy, 0);
        chk(frame_done == 0, "R6 abort gives no done", frame_done, 0);
        chk(sp_addr == 13'h00FF, "R6 sp after abort", sp_addr, 13'h00FF);

        repeat (3) tick;
        chk(wq.size() == 0, "R3 all expected writes seen", wq.size(), 0);
        chk(rq.size() == 0, "R4 all expected pops seen", rq.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule